// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block takes a single-cycle write request on the system clock and plays it out as a write cycle on an asynchronous static RAM. The RAM has an active-low chip enable, an active-low semaphore select, an active-low read/write strobe and an active-low output enable. Every timing interval is a parameter counted in system clocks. Every pin is a flop output, so no pin can glitch.

A request selects one of two targets: the memory array or the semaphore register. The target decides which of the two enables is pulled low. The request also selects which strobe closes the write. In strobe-controlled style the selected enable falls first and the read/write strobe opens and closes the write. In enable-controlled style the read/write strobe falls first and the enable opens and closes the write.

If the output enable is held low while the read/write strobe opens the write, the RAM may still be driving the data lines. The block therefore waits for those drivers to turn off before it drives its own data, and it lengthens the write pulse by that wait. The block raises a one-cycle done pulse when write recovery is over. It takes a new request only while it reports ready.

Top module: `sram_wr_seq`

## Requirements
- R1: `mem_addr` changes only on the edge that accepts a request, and at that edge all strobes are high. While an enable and `mem_rw_n` are both low, the address is held.
- R2: With `sem_sel`=0 the write pulls `mem_ce_n` low and keeps `mem_sem_n` high. With `sem_sel`=1 the roles are swapped. The two are never low together.
- R3: With `en_ctl`=0 (strobe-controlled), the sequence after the accept edge is as follows. For T_AS cycles every strobe stays high. The selected enable then falls. One cycle later `mem_rw_n` falls. `mem_rw_n` rises first, and the enable rises T_DH cycles after it.
- R4: With `en_ctl`=1 (enable-controlled), the sequence mirrors R3. `mem_rw_n` falls after the T_AS cycles. The selected enable falls one cycle later, rises first, and `mem_rw_n` rises T_DH cycles after it.
- R5: The write overlap (enable and `mem_rw_n` both low) lasts P = max(T_WP, T_EW, T_DW + W) cycles. W = T_WZ when `en_ctl`=0 and `oe_low`=1; otherwise W = 0.
- R6: `mem_dq_oe` rises W cycles into the overlap, so data is valid for at least T_DW cycles before the closing edge. It stays high for T_DH cycles after that edge. `mem_dout` holds the accepted `wdata` throughout.
- R7: With `oe_low`=1, `mem_oe_n` is low from the cycle after acceptance until the closing edge. With `oe_low`=0, `mem_oe_n` stays high.
- R8: `done` comes no earlier than T_WR cycles after the closing edge. From acceptance to `done` takes at least T_WC cycles; the recovery phase is stretched as needed and lasts at least one cycle.
- R9: `done` is high for exactly one cycle, and in that cycle `ready` is already high. `ready` is high only while idle. A `req` seen while `ready` is low is ignored.
- R10: After reset, `ready`=1 and `done`=0. The three strobes and `mem_oe_n` are high and `mem_dq_oe`=0. The same holds whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Write request, taken when `ready` is high |
| ready | output | 1 | Block idle, request will be accepted |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| sem_sel | input | 1 | 1 = semaphore target, 0 = memory array |
| en_ctl | input | 1 | 1 = enable-controlled write, 0 = strobe-controlled |
| oe_low | input | 1 | Hold output enable low during the write |
| done | output | 1 | One-cycle pulse at the end of recovery |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_dout | output | DATA_W | Data to drive onto the RAM data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_sem_n | output | 1 | Semaphore select, active low |
| mem_rw_n | output | 1 | Read/write strobe, low = write |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
The `done` pulse and the acceptance of the next request can land in the same cycle, because `ready` is already high while `done` is high. The bench provokes this by holding `req` high with a new address through a whole write cycle. It then checks three things: the request is ignored while the block is busy, `done` lasts one cycle, and the next cycle starts on the edge right after `done`, with the new address and `ready` low. A second overlap is a request arriving while the strobes are low. The bench checks that the address stays frozen and that no extra cycle follows.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ASSERT,
      ST_DSETUP,
      ST_RELEASE,
      ST_HOLD,
      ST_RECOVER
   } wr_state_t;

   typedef struct packed {
      logic en_ctl;
      logic sem;
      logic oe_low;
   } wr_attr_t;

   function automatic int imax3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_wr_plan.sv
module sram_wr_plan
   import sram_wr_pkg::*;
#(
   parameter int T_AS  = 1,
   parameter int T_WP  = 3,
   parameter int T_EW  = 3,
   parameter int T_WZ  = 2,
   parameter int T_DW  = 2,
   parameter int T_DH  = 1,
   parameter int T_WR  = 2,
   parameter int T_WC  = 8,
   parameter int CNT_W = 6
) (
   input  logic             en_ctl,
   input  logic             oe_low,
   output logic [CNT_W-1:0] pulse_len,
   output logic [CNT_W-1:0] wait_len,
   output logic [CNT_W-1:0] rec_len
);
   // overlap when the RAM may still be driving the bus, and when it cannot
   localparam int P_WAIT = imax3(T_WP, T_EW, T_DW + T_WZ);
   localparam int P_FREE = imax3(T_WP, T_EW, T_DW);
   // recovery satisfies both T_WR after the closing edge and the T_WC total
   localparam int R_WAIT = imax3(1, T_WR - T_DH - 1, T_WC - (T_AS + P_WAIT + T_DH + 2));
   localparam int R_FREE = imax3(1, T_WR - T_DH - 1, T_WC - (T_AS + P_FREE + T_DH + 2));

   logic bus_busy;
   assign bus_busy = !en_ctl && oe_low;

   assign pulse_len = bus_busy ? CNT_W'(P_WAIT) : CNT_W'(P_FREE);
   assign wait_len  = bus_busy ? CNT_W'(T_WZ)   : '0;
   assign rec_len   = bus_busy ? CNT_W'(R_WAIT) : CNT_W'(R_FREE);
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
   import sram_wr_pkg::*;
#(
   parameter int T_AS  = 1,
   parameter int T_DH  = 1,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] pulse_len,
   input  logic [CNT_W-1:0] rec_len,
   output wr_state_t        state_q,
   output wr_state_t        state_d,
   output logic [CNT_W-1:0] idx_d,
   output logic             accept,
   output logic             done_d
);
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] cur_len;

   always_comb begin
      case (state_q)
         ST_ADDR:    cur_len = CNT_W'(T_AS);
         ST_DSETUP:  cur_len = pulse_len;
         ST_RELEASE: cur_len = CNT_W'(T_DH);
         ST_RECOVER: cur_len = rec_len;
         default:    cur_len = CNT_W'(1);
      endcase
   end

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q + CNT_W'(1);
      accept  = 1'b0;
      done_d  = 1'b0;
      if (state_q == ST_IDLE) begin
         idx_d = '0;
         if (req) begin
            accept  = 1'b1;
            state_d = ST_ADDR;
         end
      end else if (idx_q == cur_len - CNT_W'(1)) begin
         idx_d = '0;
         case (state_q)
            ST_ADDR:    state_d = ST_ASSERT;
            ST_ASSERT:  state_d = ST_DSETUP;
            ST_DSETUP:  state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_RECOVER;
            default: begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
   import sram_wr_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_state_t        state_d,
   input  logic [CNT_W-1:0] idx_d,
   input  wr_attr_t         attr_d,
   input  logic [CNT_W-1:0] wait_len,
   output logic             ce_n,
   output logic             sem_n,
   output logic             rw_n,
   output logic             oe_n,
   output logic             dq_oe
);
   logic lead_low, trail_low, en_low, wr_low, oe_win, drive;

   // the leading strobe spans ASSERT..RELEASE, the trailing one only DSETUP
   assign lead_low  = (state_d == ST_ASSERT) || (state_d == ST_DSETUP) ||
                      (state_d == ST_RELEASE);
   assign trail_low = (state_d == ST_DSETUP);
   assign en_low    = attr_d.en_ctl ? trail_low : lead_low;
   assign wr_low    = attr_d.en_ctl ? lead_low  : trail_low;
   assign oe_win    = (state_d == ST_ADDR) || (state_d == ST_ASSERT) ||
                      (state_d == ST_DSETUP);
   assign drive     = ((state_d == ST_DSETUP) && (idx_d >= wait_len)) ||
                      (state_d == ST_RELEASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         sem_n <= 1'b1;
         rw_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= !(en_low && !attr_d.sem);
         sem_n <= !(en_low && attr_d.sem);
         rw_n  <= !wr_low;
         oe_n  <= !(oe_win && attr_d.oe_low);
         dq_oe <= drive;
      end
   end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 9,
   parameter int T_AS   = 1,
   parameter int T_WP   = 3,
   parameter int T_EW   = 3,
   parameter int T_WZ   = 2,
   parameter int T_DW   = 2,
   parameter int T_DH   = 1,
   parameter int T_WR   = 2,
   parameter int T_WC   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   output logic              ready,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sem_sel,
   input  logic              en_ctl,
   input  logic              oe_low,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dq_oe,
   output logic              mem_ce_n,
   output logic              mem_sem_n,
   output logic              mem_rw_n,
   output logic              mem_oe_n
);
   localparam int SPAN  = T_AS + T_WP + T_EW + T_WZ + T_DW + T_DH + T_WR + T_WC + 4;
   localparam int CNT_W = $clog2(SPAN + 1);

   if (T_AS < 1 || T_WP < 1 || T_EW < 1 || T_WZ < 1 ||
       T_DW < 1 || T_DH < 1 || T_WR < 1 || T_WC < 1) begin : g_bad_timing
      $error("sram_wr_seq: every timing interval must be at least one cycle");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_wr_seq: address and data widths must be positive");
   end

   wr_state_t        state_q, state_d;
   logic [CNT_W-1:0] idx_d, pulse_len, wait_len, rec_len;
   logic             accept, done_d;
   wr_attr_t         attr_q, attr_d;

   assign attr_d = accept ? '{en_ctl: en_ctl, sem: sem_sel, oe_low: oe_low} : attr_q;

   sram_wr_plan #(
      .T_AS(T_AS), .T_WP(T_WP), .T_EW(T_EW), .T_WZ(T_WZ), .T_DW(T_DW),
      .T_DH(T_DH), .T_WR(T_WR), .T_WC(T_WC), .CNT_W(CNT_W)
   ) u_plan (
      .en_ctl   (attr_d.en_ctl),
      .oe_low   (attr_d.oe_low),
      .pulse_len(pulse_len),
      .wait_len (wait_len),
      .rec_len  (rec_len)
   );

   sram_wr_fsm #(.T_AS(T_AS), .T_DH(T_DH), .CNT_W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .pulse_len(pulse_len),
      .rec_len  (rec_len),
      .state_q  (state_q),
      .state_d  (state_d),
      .idx_d    (idx_d),
      .accept   (accept),
      .done_d   (done_d)
   );

   sram_wr_pins #(.CNT_W(CNT_W)) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_d (state_d),
      .idx_d   (idx_d),
      .attr_d  (attr_d),
      .wait_len(wait_len),
      .ce_n    (mem_ce_n),
      .sem_n   (mem_sem_n),
      .rw_n    (mem_rw_n),
      .oe_n    (mem_oe_n),
      .dq_oe   (mem_dq_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q   <= '0;
         mem_addr <= '0;
         mem_dout <= '0;
         done     <= 1'b0;
      end else begin
         attr_q <= attr_d;
         done   <= done_d;
         if (accept) begin
            mem_addr <= addr;
            mem_dout <= wdata;
         end
      end
   end

   assign ready = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 9,
   parameter int T_WR   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dq_oe,
   input logic              mem_ce_n,
   input logic              mem_sem_n,
   input logic              mem_rw_n,
   input logic              mem_oe_n
);
   localparam logic [7:0] WR_LIM = 8'(T_WR);

   logic       en_low, overlap, overlap_q;
   logic [7:0] since_close;

   assign en_low  = !mem_ce_n || !mem_sem_n;
   assign overlap = en_low && !mem_rw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overlap_q   <= 1'b0;
         since_close <= 8'hFF;
      end else begin
         overlap_q <= overlap;
         if (overlap_q && !overlap) since_close <= 8'd1;
         else if (since_close != 8'hFF) since_close <= since_close + 8'd1;
      end
   end

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      overlap |-> $stable(mem_addr)); // R1
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_ce_n && !mem_sem_n)); // R2
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !(en_low && mem_rw_n && !mem_oe_n)); // R6
   AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dout)); // R6
   AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_close >= WR_LIM)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_ce_n && mem_sem_n && mem_rw_n && mem_oe_n && !mem_dq_oe)); // R10
endmodule

bind sram_wr_seq sram_wr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WR(T_WR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ready    (ready),
   .done     (done),
   .mem_addr (mem_addr),
   .mem_dout (mem_dout),
   .mem_dq_oe(mem_dq_oe),
   .mem_ce_n (mem_ce_n),
   .mem_sem_n(mem_sem_n),
   .mem_rw_n (mem_rw_n),
   .mem_oe_n (mem_oe_n)
);

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;
   localparam int AW = 13, DW = 9;
   localparam int TAS = 2, TWP = 3, TEW = 2, TWZ = 2, TDW = 2, TDH = 1, TWR = 4, TWC = 12;

   // [24] en_ctl, [23] sem_sel, [22] oe_low, [21:9] addr, [8:0] data
   localparam logic [24:0] VECS [6] = '{
      {1'b0, 1'b0, 1'b1, 13'h0A5C, 9'h1C3},
      {1'b0, 1'b1, 1'b0, 13'h0003, 9'h055},
      {1'b1, 1'b0, 1'b1, 13'h1234, 9'h1AA},
      {1'b1, 1'b1, 1'b1, 13'h0FF0, 9'h0F0},
      {1'b0, 1'b0, 1'b0, 13'h1FFF, 9'h1FF},
      {1'b1, 1'b0, 1'b0, 13'h0000, 9'h000}
   };

   logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
   logic sem_sel = 1'b0, en_ctl = 1'b0, oe_low = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic ready, done, mem_dq_oe, mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout;

   int total = 0, bad = 0, cyc = 0;

   always #2 clk = !clk;

   sram_wr_seq #(
      .ADDR_W(AW), .DATA_W(DW), .T_AS(TAS), .T_WP(TWP), .T_EW(TEW), .T_WZ(TWZ),
      .T_DW(TDW), .T_DH(TDH), .T_WR(TWR), .T_WC(TWC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .addr(addr), .wdata(wdata),
      .sem_sel(sem_sel), .en_ctl(en_ctl), .oe_low(oe_low), .done(done),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
      .mem_ce_n(mem_ce_n), .mem_sem_n(mem_sem_n), .mem_rw_n(mem_rw_n), .mem_oe_n(mem_oe_n)
   );

   task automatic chk(input bit ok, input string rid, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rid, what, act, exp);
      end
   endtask

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic run_vec(input logic [24:0] v);
      bit ec, sm, ol;
      int w, p, r, len, ovl, close_k;
      bit prev_ovl;
      logic [AW-1:0] prev_addr;
      logic [DW-1:0] prev_dout;
      bit prev_dq;
      ec = v[24]; sm = v[23]; ol = v[22];
      w = (!ec && ol) ? TWZ : 0;
      p = max3(TWP, TEW, TDW + w);
      r = max3(1, TWR - TDH - 1, TWC - (TAS + p + TDH + 2));
      len = TAS + 1 + p + TDH + 1 + r;
      @(negedge clk);
      chk(ready == 1'b1, "R9", "ready before request", int'(ready), 1);
      req = 1'b1; en_ctl = ec; sem_sel = sm; oe_low = ol;
      addr = v[21:9]; wdata = v[8:0];
      @(negedge clk);
      req = 1'b0; addr = ~v[21:9]; wdata = ~v[8:0];
      ovl = 0; close_k = 0; prev_ovl = 0; prev_addr = v[21:9]; prev_dout = '0; prev_dq = 0;
      for (int k = 1; k <= len + 2; k++) begin
         bit s_as, s_asrt, s_dat, s_rel, lead, trail, enl, rwl, dq_e, cur_ovl;
         string rid_ord;
         rid_ord = ec ? "R4" : "R3";
         s_as   = (k <= TAS);
         s_asrt = (k == TAS + 1);
         s_dat  = (k >= TAS + 2) && (k <= TAS + 1 + p);
         s_rel  = (k > TAS + 1 + p) && (k <= TAS + 1 + p + TDH);
         lead   = s_asrt || s_dat || s_rel;
         trail  = s_dat;
         enl    = ec ? trail : lead;
         rwl    = ec ? lead : trail;
         dq_e   = (s_dat && (k - (TAS + 2)) >= w) || s_rel;
         chk(mem_ce_n == !(enl && !sm), sm ? "R2" : rid_ord, "ce_n", int'(mem_ce_n), int'(!(enl && !sm)));
         chk(mem_sem_n == !(enl && sm), sm ? rid_ord : "R2", "sem_n", int'(mem_sem_n), int'(!(enl && sm)));
         chk(mem_rw_n == !rwl, rid_ord, "rw_n", int'(mem_rw_n), int'(!rwl));
         chk(mem_oe_n == !(ol && (s_as || s_asrt || s_dat)), "R7", "oe_n",
             int'(mem_oe_n), int'(!(ol && (s_as || s_asrt || s_dat))));
         chk(mem_dq_oe == dq_e, "R6", "dq_oe", int'(mem_dq_oe), int'(dq_e));
         chk(mem_addr == v[21:9], "R1", "address", int'(mem_addr), int'(v[21:9]));
         if (mem_dq_oe) chk(mem_dout == v[8:0], "R6", "driven data", int'(mem_dout), int'(v[8:0]));
         chk(done == (k == len + 1), "R9", "done", int'(done), int'(k == len + 1));
         chk(ready == (k >= len + 1), "R9", "ready", int'(ready), int'(k >= len + 1));
         // pin-level observers
         cur_ovl = (!mem_ce_n || !mem_sem_n) && !mem_rw_n;
         if (cur_ovl && prev_ovl && mem_addr != prev_addr)
            chk(1'b0, "R1", "address moved during overlap", int'(mem_addr), int'(prev_addr));
         if (cur_ovl) ovl++;
         if (prev_ovl && !cur_ovl) begin
            close_k = k;
            chk(prev_dq && prev_dout == v[8:0], "R6", "data at closing edge",
                int'(prev_dout), int'(v[8:0]));
         end
         if (done) begin
            chk(k - close_k >= TWR, "R8", "cycles closing edge to done", k - close_k, TWR);
            chk(k - 1 >= TWC, "R8", "cycle length", k - 1, TWC);
         end
         prev_ovl = cur_ovl; prev_addr = mem_addr; prev_dout = mem_dout; prev_dq = mem_dq_oe;
         if (k < len + 2) @(negedge clk);
      end
      chk(ovl == p, "R5", "overlap width", ovl, p);
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk(ready == 1'b1 && done == 1'b0, "R10", "idle flags in reset", int'({ready, done}), 2);
      chk({mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_dq_oe} == 5'b11110, "R10",
          "pins in reset", int'({mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_dq_oe}), 'h1E);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1 && mem_rw_n == 1'b1, "R10", "idle after reset", int'({ready, mem_rw_n}), 3);

      foreach (VECS[i]) run_vec(VECS[i]);

      // requests while busy are ignored
      @(negedge clk);
      req = 1'b1; en_ctl = 1'b0; sem_sel = 1'b0; oe_low = 1'b0; addr = 13'h0111; wdata = 9'h011;
      @(negedge clk);
      addr = 13'h1EEE; wdata = 9'h1EE;
      repeat (3) @(negedge clk);
      req = 1'b0;
      wait_done(n);
      chk(done == 1'b1, "R9", "done after busy pokes", int'(done), 1);
      chk(mem_addr == 13'h0111, "R1", "address kept despite busy request", int'(mem_addr), 'h111);
      chk(mem_dout == 9'h011, "R9", "data kept despite busy request", int'(mem_dout), 'h11);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk(ready && mem_rw_n && mem_ce_n && !done, "R9", "no cycle from ignored request",
             int'({ready, mem_rw_n, mem_ce_n, done}), 'hE);
      end

      // request held through done: accepted on the edge after done
      req = 1'b1; sem_sel = 1'b1; en_ctl = 1'b1; oe_low = 1'b1; addr = 13'h0222; wdata = 9'h022;
      @(negedge clk);
      addr = 13'h0333; wdata = 9'h033;
      wait_done(n);
      chk(done && ready, "R9", "done and ready together", int'({done, ready}), 3);
      @(negedge clk);
      req = 1'b0;
      chk(!ready && !done, "R9", "back-to-back accepted", int'({ready, done}), 0);
      chk(mem_addr == 13'h0333, "R1", "new address on back-to-back accept", int'(mem_addr), 'h333);
      wait_done(n);
      chk(done == 1'b1 && mem_dout == 9'h033, "R9", "second write completes",
          int'({done, mem_dout}), 'h233);
      @(negedge clk);
      chk(ready && !done && mem_sem_n && mem_oe_n, "R10", "idle after back-to-back",
          int'({ready, done, mem_sem_n, mem_oe_n}), 'hB);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule